// File: doc/BRIEF.md
# Receive Descriptor Walker

This block is the control sequencer of a receive DMA engine. It walks a ring of descriptors held in memory, one fixed-size entry per frame. A software run bit starts it and stops it. Once running, it requests the descriptor at the current address and inspects the valid flag returned with it. With a usable descriptor it waits for a frame, grants the transfer to an external data mover, and then advances to the next entry. A descriptor can carry a wrap mark, which sends the walk back to the programmed table base.

A descriptor returned with its valid flag clear parks the engine in a suspend state and raises a buffer-unavailable flag. Software then refills the ring and pulses a poll strobe to retry the same entry. Clearing the run bit never cuts a frame short: a transfer in flight finishes first. Only the very first start after reset loads the table base. A later restart resumes at the entry following the last one consumed.

The engine's coarse state (stop, running, suspend) and its current descriptor address are visible as read-only outputs.

Top module: `rxdesc_walker`

## Requirements
- R1: After reset the state output reads stop (2'b00), the current address is zero, and fetch_req, xfer_active and buf_unavail are all low.
- R2: When run_en is high in the stop state and no start has happened since reset, the next cycle shows running (2'b01), with fetch_req high and fetch_addr equal to base_addr.
- R3: A fetch answered with desc_valid high ends the request and holds the engine in running. A later frame_avail makes xfer_active high from the following cycle until xfer_done.
- R4: A fetch answered with desc_valid low moves the engine to suspend (2'b10) in the next cycle, with buf_unavail high and fetch_req low. It stays there without fetching until a poll strobe or a stop.
- R5: A poll strobe in suspend re-issues the fetch at the same address and shows running. A valid answer to that fetch clears buf_unavail.
- R6: xfer_done during a transfer on a descriptor without a wrap mark advances cur_addr by the descriptor size. When run_en is high, a fetch at the new address follows in the next cycle.
- R7: xfer_done on a descriptor whose wrap mark was set at fetch time sets cur_addr to base_addr.
- R8: Clearing run_en during a transfer leaves xfer_active high until xfer_done. The engine then enters stop with cur_addr already advanced.
- R9: A restart after any stop fetches from the current address, not from base_addr, even if base_addr has changed since.
- R10: Clearing run_en while waiting for a frame, or while suspended, gives stop in the next cycle and clears buf_unavail. Clearing it during a pending fetch keeps the request until desc_ack, then gives stop.
- R11: poll has no effect outside suspend. It starts no fetch and changes neither the state nor cur_addr.
- R12: The state output never shows the code 2'b11, and fetch_req is high only in running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Software run bit, level |
| poll | input | 1 | Software poll strobe for a retry in suspend |
| base_addr | input | AW | Descriptor table base address |
| fetch_req | output | 1 | Descriptor fetch request, held until desc_ack |
| fetch_addr | output | AW | Address of the descriptor being fetched |
| desc_ack | input | 1 | Fetch response strobe |
| desc_valid | input | 1 | Valid flag of the returned descriptor |
| desc_wrap | input | 1 | Wrap mark of the returned descriptor |
| frame_avail | input | 1 | A received frame is ready to move |
| xfer_active | output | 1 | Frame transfer granted to the data mover |
| xfer_done | input | 1 | Data mover finished the frame |
| state_o | output | 2 | 00 stop, 01 running, 10 suspend |
| cur_addr | output | AW | Current descriptor address |
| buf_unavail | output | 1 | Buffer-unavailable status |

## Verification
The bench builds the walker with a 12-bit address and an 8-byte descriptor, so the base, the advanced entries and the wrap target are small, distinct numbers that are easy to compare. A single directed run covers the first start from the base, a suspend and poll retry, a stop during a transfer, a restart after the base has been reprogrammed, a wrap, and stops from the waiting, suspended and fetching phases.

// File: rtl/rxdw_pkg.sv
package rxdw_pkg;

    typedef enum logic [1:0] {
        ST_STOP = 2'b00,
        ST_RUN  = 2'b01,
        ST_SUSP = 2'b10
    } run_state_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_FETCH,
        PH_HOLD,
        PH_MOVE,
        PH_PARK
    } phase_e;

    typedef struct packed {
        logic ld_start;
        logic cap_desc;
        logic advance;
        logic set_bu;
        logic clr_bu;
    } seq_ctl_t;

    function automatic run_state_e state_of(input phase_e p);
        case (p)
            PH_IDLE: return ST_STOP;
            PH_PARK: return ST_SUSP;
            default: return ST_RUN;
        endcase
    endfunction

endpackage

// File: rtl/rxdw_seq.sv
module rxdw_seq
    import rxdw_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     run_en,
    input  logic     poll,
    input  logic     desc_ack,
    input  logic     desc_valid,
    input  logic     frame_avail,
    input  logic     xfer_done,
    output phase_e   phase,
    output seq_ctl_t ctl
);

    typedef struct packed {
        phase_e phase;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        ctl = '0;
        case (r_q.phase)
            PH_IDLE: begin
                if (run_en) begin
                    r_d.phase    = PH_FETCH;
                    ctl.ld_start = 1'b1;
                end
            end
            PH_FETCH: begin
                if (desc_ack) begin
                    ctl.cap_desc = 1'b1;
                    if (!run_en) begin
                        r_d.phase  = PH_IDLE;
                        ctl.clr_bu = 1'b1;
                    end else if (desc_valid) begin
                        r_d.phase  = PH_HOLD;
                        ctl.clr_bu = 1'b1;
                    end else begin
                        r_d.phase  = PH_PARK;
                        ctl.set_bu = 1'b1;
                    end
                end
            end
            PH_HOLD: begin
                if (!run_en) begin
                    r_d.phase  = PH_IDLE;
                    ctl.clr_bu = 1'b1;
                end else if (frame_avail) begin
                    r_d.phase = PH_MOVE;
                end
            end
            PH_MOVE: begin
                if (xfer_done) begin
                    ctl.advance = 1'b1;
                    r_d.phase   = run_en ? PH_FETCH : PH_IDLE;
                end
            end
            PH_PARK: begin
                if (!run_en) begin
                    r_d.phase  = PH_IDLE;
                    ctl.clr_bu = 1'b1;
                end else if (poll) begin
                    r_d.phase = PH_FETCH;
                end
            end
            default: r_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{phase: PH_IDLE};
        else        r_q <= r_d;
    end

    assign phase = r_q.phase;

endmodule

// File: rtl/rxdw_ptr.sv
module rxdw_ptr
    import rxdw_pkg::*;
#(
    parameter int AW         = 32,
    parameter int DESC_BYTES = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  seq_ctl_t      ctl,
    input  logic [AW-1:0] base_addr,
    input  logic          desc_wrap,
    output logic [AW-1:0] cur_addr
);

    localparam logic [AW-1:0] STEP = AW'(DESC_BYTES);

    typedef struct packed {
        logic [AW-1:0] cur;
        logic          wrap;
        logic          started;
    } ptr_regs_t;

    ptr_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (ctl.ld_start) begin
            if (!r_q.started) r_d.cur = base_addr;
            r_d.started = 1'b1;
        end
        if (ctl.cap_desc) r_d.wrap = desc_wrap;
        if (ctl.advance) begin
            r_d.cur  = r_q.wrap ? base_addr : r_q.cur + STEP;
            r_d.wrap = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cur_addr = r_q.cur;

endmodule

// File: rtl/rxdw_flag.sv
module rxdw_flag
    import rxdw_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  seq_ctl_t ctl,
    output logic     buf_unavail
);

    typedef struct packed {
        logic bu;
    } flag_regs_t;

    flag_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (ctl.set_bu)      r_d.bu = 1'b1;
        else if (ctl.clr_bu) r_d.bu = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign buf_unavail = r_q.bu;

endmodule

// File: rtl/rxdesc_walker.sv
module rxdesc_walker
    import rxdw_pkg::*;
#(
    parameter int AW         = 32,
    parameter int DESC_BYTES = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_en,
    input  logic          poll,
    input  logic [AW-1:0] base_addr,
    output logic          fetch_req,
    output logic [AW-1:0] fetch_addr,
    input  logic          desc_ack,
    input  logic          desc_valid,
    input  logic          desc_wrap,
    input  logic          frame_avail,
    output logic          xfer_active,
    input  logic          xfer_done,
    output logic [1:0]    state_o,
    output logic [AW-1:0] cur_addr,
    output logic          buf_unavail
);

    phase_e   phase;
    seq_ctl_t ctl;

    rxdw_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_en      (run_en),
        .poll        (poll),
        .desc_ack    (desc_ack),
        .desc_valid  (desc_valid),
        .frame_avail (frame_avail),
        .xfer_done   (xfer_done),
        .phase       (phase),
        .ctl         (ctl)
    );

    rxdw_ptr #(
        .AW         (AW),
        .DESC_BYTES (DESC_BYTES)
    ) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl       (ctl),
        .base_addr (base_addr),
        .desc_wrap (desc_wrap),
        .cur_addr  (cur_addr)
    );

    rxdw_flag u_flag (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctl         (ctl),
        .buf_unavail (buf_unavail)
    );

    assign fetch_req   = (phase == PH_FETCH);
    assign xfer_active = (phase == PH_MOVE);
    assign fetch_addr  = cur_addr;
    assign state_o     = state_of(phase);

endmodule

// File: rtl/rxdw_chk.sv
module rxdw_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          run_en,
    input logic          fetch_req,
    input logic          desc_ack,
    input logic          xfer_active,
    input logic          xfer_done,
    input logic [1:0]    state_o,
    input logic [AW-1:0] cur_addr,
    input logic          buf_unavail
);

    // R4
    susp_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'b10) |-> buf_unavail);

    // R3
    xfer_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_active |-> (state_o == 2'b01));

    // R8
    xfer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_active && !xfer_done) |=> xfer_active);

    // R6
    xfer_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_active && xfer_done) |=> !xfer_active);

    // R10
    fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && !desc_ack) |=> fetch_req);

    // R11
    stop_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'b00 && !run_en) |=> $stable(cur_addr));

    // R12
    state_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o != 2'b11) && (!fetch_req || state_o == 2'b01));

endmodule

bind rxdesc_walker rxdw_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_en      (run_en),
    .fetch_req   (fetch_req),
    .desc_ack    (desc_ack),
    .xfer_active (xfer_active),
    .xfer_done   (xfer_done),
    .state_o     (state_o),
    .cur_addr    (cur_addr),
    .buf_unavail (buf_unavail)
);

// File: tb/sim_rxdesc_walker.sv
`timescale 1ns/1ps
module sim_rxdesc_walker;

    localparam int AW = 12;
    localparam int DB = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run_en = 1'b0, poll = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic          fetch_req, xfer_active, buf_unavail;
    logic [AW-1:0] fetch_addr, cur_addr;
    logic          desc_ack = 1'b0, desc_valid = 1'b0, desc_wrap = 1'b0;
    logic          frame_avail = 1'b0, xfer_done = 1'b0;
    logic [1:0]    state_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rxdesc_walker #(.AW(AW), .DESC_BYTES(DB)) u0 (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .poll(poll),
        .base_addr(base_addr), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .desc_ack(desc_ack), .desc_valid(desc_valid), .desc_wrap(desc_wrap),
        .frame_avail(frame_avail), .xfer_active(xfer_active), .xfer_done(xfer_done),
        .state_o(state_o), .cur_addr(cur_addr), .buf_unavail(buf_unavail)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic ack(input logic v, input logic w);
        desc_ack = 1'b1; desc_valid = v; desc_wrap = w;
        step();
        desc_ack = 1'b0; desc_valid = 1'b0; desc_wrap = 1'b0;
    endtask

    task automatic pulse_frame();
        frame_avail = 1'b1; step(); frame_avail = 1'b0;
    endtask

    task automatic pulse_done();
        xfer_done = 1'b1; step(); xfer_done = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 state", state_o, 2'b00);
        chk("R1 cur_addr", cur_addr, 0);
        chk("R1 fetch_req", fetch_req, 0);
        chk("R1 xfer_active", xfer_active, 0);
        chk("R1 buf_unavail", buf_unavail, 0);
    endtask

    task automatic t_first_frame();
        base_addr = 12'h100;
        run_en = 1'b1; step();
        chk("R2 state", state_o, 2'b01);
        chk("R2 fetch_req", fetch_req, 1);
        chk("R2 fetch_addr", fetch_addr, 12'h100);
        ack(1'b1, 1'b0);
        chk("R3 req dropped", fetch_req, 0);
        chk("R3 state", state_o, 2'b01);
        poll = 1'b1; step(); poll = 1'b0;
        chk("R11 poll in run fetch_req", fetch_req, 0);
        chk("R11 poll in run state", state_o, 2'b01);
        chk("R3 no xfer before frame", xfer_active, 0);
        pulse_frame();
        chk("R3 xfer_active", xfer_active, 1);
        step();
        chk("R3 xfer held", xfer_active, 1);
        pulse_done();
        chk("R6 xfer ended", xfer_active, 0);
        chk("R6 cur advanced", cur_addr, 12'h108);
        chk("R6 refetch", fetch_req, 1);
        chk("R6 fetch_addr", fetch_addr, 12'h108);
    endtask

    task automatic t_suspend();
        ack(1'b0, 1'b0);
        chk("R4 state", state_o, 2'b10);
        chk("R4 buf_unavail", buf_unavail, 1);
        chk("R4 fetch_req", fetch_req, 0);
        step(); step();
        chk("R4 still suspended", state_o, 2'b10);
        chk("R4 no fetch", fetch_req, 0);
        poll = 1'b1; step(); poll = 1'b0;
        chk("R5 state", state_o, 2'b01);
        chk("R5 refetch", fetch_req, 1);
        chk("R5 same addr", fetch_addr, 12'h108);
        ack(1'b1, 1'b0);
        chk("R5 flag cleared", buf_unavail, 0);
    endtask

    task automatic t_stop_in_xfer();
        pulse_frame();
        run_en = 1'b0; step();
        chk("R8 xfer kept", xfer_active, 1);
        chk("R8 state", state_o, 2'b01);
        pulse_done();
        chk("R8 stopped", state_o, 2'b00);
        chk("R8 cur advanced", cur_addr, 12'h110);
        chk("R8 no fetch", fetch_req, 0);
    endtask

    task automatic t_restart_wrap();
        base_addr = 12'h200;
        run_en = 1'b1; step();
        chk("R9 resume addr", fetch_addr, 12'h110);
        chk("R9 fetch_req", fetch_req, 1);
        ack(1'b1, 1'b1);
        pulse_frame();
        pulse_done();
        chk("R7 wrapped to base", cur_addr, 12'h200);
        chk("R7 fetch_addr", fetch_addr, 12'h200);
    endtask

    task automatic t_stops();
        ack(1'b1, 1'b0);
        run_en = 1'b0; step();
        chk("R10 stop from wait", state_o, 2'b00);
        poll = 1'b1; step(); poll = 1'b0;
        chk("R11 poll in stop state", state_o, 2'b00);
        chk("R11 poll in stop fetch", fetch_req, 0);
        chk("R11 poll in stop addr", cur_addr, 12'h200);
        run_en = 1'b1; step();
        chk("R9 unused desc refetched", fetch_addr, 12'h200);
        ack(1'b0, 1'b0);
        chk("R4 suspend again", state_o, 2'b10);
        run_en = 1'b0; step();
        chk("R10 stop from suspend", state_o, 2'b00);
        chk("R10 flag cleared", buf_unavail, 0);
        run_en = 1'b1; step();
        run_en = 1'b0; step();
        chk("R10 fetch kept", fetch_req, 1);
        chk("R10 still running", state_o, 2'b01);
        ack(1'b1, 1'b0);
        chk("R10 stop after ack", state_o, 2'b00);
        chk("R10 addr kept", cur_addr, 12'h200);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        step();
        t_reset();
        t_first_frame();
        t_suspend();
        t_stop_in_xfer();
        t_restart_wrap();
        t_stops();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule